// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects an on-chip master to an external asynchronous static RAM of 262,144 sixteen-bit words. On the host side, a request carries an address, write data, one strobe per byte lane and a read/write flag. The master holds the request until the controller returns a one-cycle ready pulse. For a read, the captured word comes with that pulse.

On the memory side, the controller drives registered, active-low strobes: chip enable, write enable, output enable and one byte enable per lane. It also drives an 18-bit address and a shared 16-bit bidirectional data bus. The memory timing is given in nanoseconds together with the clock period, and the controller converts it into wait-state counts. Read access, write pulse, bus release and cycle spacing are each timed separately.

A read keeps the strobes active for the full address access time, even when only the byte enables differ from the previous access. The memory only guarantees its shorter byte-enable access time when the address also toggles. After a read, the controller keeps the bus released long enough for the memory's output drivers to turn off before any write drives it.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While reset is applied and until the first request, `mem_ce_n`, `mem_we_n`, `mem_oe_n` and every bit of `mem_be_n` are high, `host_ready` is low and the data bus is released.
- R2: A read returns in `host_rdata` the stored word on every lane whose `host_be` bit is 1. Lanes whose bit is 0 read as zero. `host_be[0]` and `mem_be_n[0]` belong to bits 7:0, and `host_be[1]` and `mem_be_n[1]` belong to bits 15:8.
- R3: A write changes only the lanes whose `host_be` bit is 1. During the access, `mem_be_n[i]` is low exactly when `host_be[i]` is 1.
- R4: During a read, `mem_ce_n` and `mem_oe_n` are low and `mem_we_n` is high for at least ceil(max(tAA, tRC) / clock period) cycles (5 at defaults) before data is captured. This holds even when only the byte enables differ from the previous access.
- R5: `mem_we_n` is low for exactly `WE_PULSE_CYC` cycles (3 at defaults), and only while `mem_ce_n` is low and `mem_oe_n` is high. Chip enable is low and the address is unchanged in the cycle before the pulse, and chip enable is still low in the cycle after it.
- R6: The controller drives the data bus only during a write access, with `mem_ce_n` low and `mem_oe_n` high, and the bus then carries the host write data. It never drives the bus while `mem_oe_n` is low.
- R7: After `mem_oe_n` rises, the bus stays released for at least ceil(tHZ / clock period) cycles (2 at defaults) before a write drives it.
- R8: Each accepted request produces exactly one single-cycle `host_ready` pulse. A new request is accepted only from the idle state. For a read, `host_rdata` is valid in the cycle where `host_ready` is high.
- R9: Consecutive falling edges of `mem_ce_n` are at least ceil(tRC / clock period) cycles apart (5 at defaults).
- R10: With `host_be` equal to 0, no byte enable is asserted. A write then leaves the memory unchanged, and a read returns zero.
- R11: While `mem_ce_n` is low, `mem_addr` holds the address latched when the request was accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Request, held until `host_ready` |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 18 | Word address |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Byte lane strobes, bit 0 = low byte |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Captured read word |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_be_n | output | 2 | Byte enables, bit 0 lower lane, active low |
| mem_addr | output | 18 | Memory word address |
| mem_dq | inout | 16 | Bidirectional data bus |

## Verification
The assertions assume that the master holds its request and its fields steady until it sees ready. They also assume that the master drops the request in the cycle after ready, and that the memory drives the bus only while chip enable and output enable are low and write enable is high. The bench driver follows these rules: it raises a request at a falling clock edge and releases it at the first falling edge where ready is seen. The memory model in the bench drives the bus only under the read condition. Random addresses cluster in a small window so that reads hit earlier writes. A few addresses lie at the top of the range. Directed sequences cover byte-only changes between reads, all-lanes-off accesses and a read followed directly by a write.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_RECOVER
    } ctrl_state_e;

    // Whole clock cycles needed to cover a delay in nanoseconds.
    function automatic int cycles_for(input int delay_ns, input int period_ns);
        return (delay_ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_capture.sv
module sram_lane_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] lane_d, lane_q;

    always_comb begin
        lane_d = lane_q;
        if (cap) begin
            lane_d = en ? din : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign dout = lane_q;

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 18,
    parameter int DATA_W        = 16,
    parameter int LANE_W        = 8,
    parameter int CLK_PERIOD_NS = 20,
    parameter int T_RC_NS       = 85,
    parameter int T_AA_NS       = 85,
    parameter int T_HZ_NS       = 35,
    parameter int WE_PULSE_CYC  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_req,
    input  logic                     host_we,
    input  logic [ADDR_W-1:0]        host_addr,
    input  logic [DATA_W-1:0]        host_wdata,
    input  logic [DATA_W/LANE_W-1:0] host_be,
    output logic                     host_ready,
    output logic [DATA_W-1:0]        host_rdata,
    output logic                     mem_ce_n,
    output logic                     mem_we_n,
    output logic                     mem_oe_n,
    output logic [DATA_W/LANE_W-1:0] mem_be_n,
    output logic [ADDR_W-1:0]        mem_addr,
    inout  wire  [DATA_W-1:0]        mem_dq
);

    localparam int LANES   = DATA_W / LANE_W;
    localparam int RC_CYC  = cycles_for(T_RC_NS, CLK_PERIOD_NS);
    localparam int AA_CYC  = cycles_for(T_AA_NS, CLK_PERIOD_NS);
    // Byte-only changes need the full access time, so reads always wait it.
    localparam int RD_WAIT = imax(1, imax(RC_CYC, AA_CYC));
    localparam int HZ_WAIT = imax(1, cycles_for(T_HZ_NS, CLK_PERIOD_NS));
    localparam int WR_LEN  = WE_PULSE_CYC + 2;
    localparam int WR_GAP  = (RC_CYC > WR_LEN) ? (RC_CYC - WR_LEN) : 0;
    localparam int CNT_MAX = imax(RD_WAIT, imax(WE_PULSE_CYC, imax(HZ_WAIT, WR_GAP + 1)));
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        ctrl_state_e       state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  lane_en;
        logic              ce_n;
        logic              we_n;
        logic              oe_n;
        logic [LANES-1:0]  be_n;
        logic              drive;
        logic              ready;
    } ctrl_regs_t;

    ctrl_regs_t       cur_d, cur_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             cap_stb;
    logic             bus_drive;

    sram_wait_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    always_comb begin
        cur_d       = cur_q;
        cur_d.ready = 1'b0;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        cap_stb     = 1'b0;

        unique case (cur_q.state)
            ST_IDLE: begin
                if (host_req) begin
                    cur_d.addr    = host_addr;
                    cur_d.lane_en = host_be;
                    cur_d.be_n    = ~host_be;
                    cur_d.ce_n    = 1'b0;
                    if (host_we) begin
                        cur_d.wdata = host_wdata;
                        cur_d.drive = 1'b1;
                        cur_d.state = ST_WR_SETUP;
                    end else begin
                        cur_d.oe_n  = 1'b0;
                        cur_d.state = ST_RD;
                        tmr_load    = 1'b1;
                        tmr_val     = CNT_W'(RD_WAIT - 1);
                    end
                end
            end

            ST_RD: begin
                if (tmr_zero) begin
                    cap_stb     = 1'b1;
                    cur_d.ready = 1'b1;
                    cur_d.ce_n  = 1'b1;
                    cur_d.oe_n  = 1'b1;
                    cur_d.be_n  = '1;
                    cur_d.state = ST_RECOVER;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(HZ_WAIT - 1);
                end
            end

            ST_WR_SETUP: begin
                cur_d.we_n  = 1'b0;
                cur_d.state = ST_WR_PULSE;
                tmr_load    = 1'b1;
                tmr_val     = CNT_W'(WE_PULSE_CYC - 1);
            end

            ST_WR_PULSE: begin
                if (tmr_zero) begin
                    cur_d.we_n  = 1'b1;
                    cur_d.state = ST_WR_HOLD;
                end
            end

            ST_WR_HOLD: begin
                cur_d.ce_n  = 1'b1;
                cur_d.be_n  = '1;
                cur_d.drive = 1'b0;
                cur_d.ready = 1'b1;
                cur_d.state = ST_RECOVER;
                tmr_load    = 1'b1;
                tmr_val     = CNT_W'(WR_GAP);
            end

            ST_RECOVER: begin
                if (tmr_zero) begin
                    cur_d.state = ST_IDLE;
                end
            end

            default: begin
                cur_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state   <= ST_IDLE;
            cur_q.addr    <= '0;
            cur_q.wdata   <= '0;
            cur_q.lane_en <= '0;
            cur_q.ce_n    <= 1'b1;
            cur_q.we_n    <= 1'b1;
            cur_q.oe_n    <= 1'b1;
            cur_q.be_n    <= '1;
            cur_q.drive   <= 1'b0;
            cur_q.ready   <= 1'b0;
        end else begin
            cur_q <= cur_d;
        end
    end

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            sram_lane_capture #(
                .W (LANE_W)
            ) u_cap (
                .clk   (clk),
                .rst_n (rst_n),
                .cap   (cap_stb),
                .en    (cur_q.lane_en[g]),
                .din   (mem_dq[g*LANE_W +: LANE_W]),
                .dout  (host_rdata[g*LANE_W +: LANE_W])
            );
        end
    endgenerate

    assign bus_drive  = cur_q.drive;
    assign mem_dq     = bus_drive ? cur_q.wdata : {DATA_W{1'bz}};
    assign host_ready = cur_q.ready;
    assign mem_ce_n   = cur_q.ce_n;
    assign mem_we_n   = cur_q.we_n;
    assign mem_oe_n   = cur_q.oe_n;
    assign mem_be_n   = cur_q.be_n;
    assign mem_addr   = cur_q.addr;

endmodule

// File: rtl/sram_bus_ctrl_chk.sv
module sram_bus_ctrl_chk #(
    parameter int ADDR_W   = 18,
    parameter int RD_WAIT  = 5,
    parameter int HZ_WAIT  = 2,
    parameter int WE_PULSE = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              we_n,
    input logic              oe_n,
    input logic [ADDR_W-1:0] addr,
    input logic              drive,
    input logic              ready
);

    logic [7:0] oe_lo_cnt, we_lo_cnt, oe_hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_lo_cnt <= '0;
            we_lo_cnt <= '0;
            oe_hi_cnt <= 8'hFF;
        end else begin
            oe_lo_cnt <= oe_n ? 8'd0 : ((oe_lo_cnt == 8'hFF) ? oe_lo_cnt : oe_lo_cnt + 8'd1);
            we_lo_cnt <= we_n ? 8'd0 : ((we_lo_cnt == 8'hFF) ? we_lo_cnt : we_lo_cnt + 8'd1);
            oe_hi_cnt <= !oe_n ? 8'd0 : ((oe_hi_cnt == 8'hFF) ? oe_hi_cnt : oe_hi_cnt + 8'd1);
        end
    end

    a_r4_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (!ce_n && we_n));

    a_r4_read_length: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_n) |-> (oe_lo_cnt >= 8'(RD_WAIT)));

    a_r5_we_window: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (!ce_n && oe_n));

    a_r5_we_length: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (we_lo_cnt == 8'(WE_PULSE)));

    a_r5_we_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> ($stable(addr) && !$past(ce_n)));

    a_r5_we_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (!ce_n && drive));

    a_r6_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !drive);

    a_r6_drive_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
        drive |-> !ce_n);

    a_r7_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive) |-> (oe_hi_cnt >= 8'(HZ_WAIT)));

    a_r8_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    a_r11_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && $past(!ce_n)) |-> $stable(addr));

endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .RD_WAIT  (RD_WAIT),
    .HZ_WAIT  (HZ_WAIT),
    .WE_PULSE (WE_PULSE_CYC)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ce_n  (mem_ce_n),
    .we_n  (mem_we_n),
    .oe_n  (mem_oe_n),
    .addr  (mem_addr),
    .drive (bus_drive),
    .ready (host_ready)
);

// File: tb/sram_bus_ctrl_tb_top.sv
module sram_bus_ctrl_tb_top;

    localparam int AW     = 18;
    localparam int DW     = 16;
    localparam int PER    = 20;
    localparam int RD_MIN = (85 + PER - 1) / PER;
    localparam int HZ_MIN = (35 + PER - 1) / PER;
    localparam int RC_MIN = (85 + PER - 1) / PER;
    localparam int WE_LEN = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_req = 1'b0;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [1:0]    host_be = '0;
    logic          host_ready;
    logic [DW-1:0] host_rdata;
    logic          mem_ce_n, mem_we_n, mem_oe_n;
    logic [1:0]    mem_be_n;
    logic [AW-1:0] mem_addr;
    wire  [DW-1:0] mem_dq;

    int n_chk = 0;
    int n_err = 0;
    int n_ops = 0;
    int n_ready = 0;

    always #10 clk = ~clk;

    sram_bus_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_be    (host_be),
        .host_ready (host_ready),
        .host_rdata (host_rdata),
        .mem_ce_n   (mem_ce_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_be_n   (mem_be_n),
        .mem_addr   (mem_addr),
        .mem_dq     (mem_dq)
    );

    // ---------------- memory model and shadow ----------------
    logic [DW-1:0] sram_arr [logic [AW-1:0]];
    logic [DW-1:0] shadow   [logic [AW-1:0]];
    logic [DW-1:0] model_word = '0;
    logic          model_drv;

    function automatic logic [DW-1:0] init_word(input logic [AW-1:0] a);
        return (a[15:0] * 16'd7) ^ {14'h2A5, a[17:16]};
    endfunction

    function automatic logic [DW-1:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a, input logic [1:0] be);
        logic [DW-1:0] w;
        w = shadow.exists(a) ? shadow[a] : init_word(a);
        return w & lane_mask(be);
    endfunction

    assign model_drv = !mem_ce_n && mem_we_n && !mem_oe_n && (mem_be_n != 2'b11);
    assign mem_dq    = model_drv ? model_word : 16'hzzzz;

    always @(negedge clk) begin
        if (rst_n && !mem_ce_n && !mem_we_n) begin
            logic [DW-1:0] w;
            w = sram_arr.exists(mem_addr) ? sram_arr[mem_addr] : init_word(mem_addr);
            if (!mem_be_n[0]) w[7:0]  = mem_dq[7:0];
            if (!mem_be_n[1]) w[15:8] = mem_dq[15:8];
            sram_arr[mem_addr] = w;
        end
        model_word <= sram_arr.exists(mem_addr) ? sram_arr[mem_addr] : init_word(mem_addr);
    end

    // ---------------- check helpers ----------------
    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // ---------------- port monitors ----------------
    logic [AW-1:0] cur_addr = '0;
    logic [DW-1:0] cur_wdata = '0;
    logic [1:0]    cur_be = '0;
    int  oe_lo = 0, we_lo = 0, oe_hi = 1000, ce_gap = 0;
    bit  ce_seen = 1'b0;
    logic p_oe = 1'b1, p_we = 1'b1, p_ce = 1'b1, p_rdy = 1'b0;
    logic [AW-1:0] p_addr = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            // R4: read strobe window length
            if (!mem_oe_n) oe_lo++;
            else if (!p_oe) begin
                chk(oe_lo >= RD_MIN, "R4 read window cycles", oe_lo, RD_MIN);
                oe_lo = 0;
            end
            // R5: write pulse length, setup and hold
            if (!mem_we_n) begin
                we_lo++;
                if (p_we) chk(!p_ce && mem_addr == p_addr, "R5 setup ce/addr", {p_ce, 14'h0, p_addr}, {1'b0, 14'h0, mem_addr});
            end else if (!p_we) begin
                chk(we_lo == WE_LEN, "R5 pulse cycles", we_lo, WE_LEN);
                chk(!mem_ce_n, "R5 hold ce", mem_ce_n, 0);
                // R6: bus carries write data on enabled lanes
                chk((mem_dq & lane_mask(cur_be)) == (cur_wdata & lane_mask(cur_be)),
                    "R6 bus write data", mem_dq & lane_mask(cur_be), cur_wdata & lane_mask(cur_be));
                we_lo = 0;
            end
            // R3/R10: byte enables follow strobes
            if (!mem_ce_n && p_ce)
                chk(mem_be_n == ~cur_be, "R3 lane enables", mem_be_n, ~cur_be);
            // R7 and R9 at chip-enable fall; R11 address
            if (!mem_ce_n && p_ce) begin
                if (mem_oe_n) chk(oe_hi >= HZ_MIN, "R7 turnaround cycles", oe_hi, HZ_MIN);
                if (ce_seen) chk(ce_gap >= RC_MIN, "R9 access spacing", ce_gap, RC_MIN);
                ce_gap  = 0;
                ce_seen = 1'b1;
                chk(mem_addr == cur_addr, "R11 address", mem_addr, cur_addr);
            end
            ce_gap++;
            if (mem_oe_n) oe_hi++; else oe_hi = 0;
            // R8: single-cycle ready
            if (host_ready) begin
                n_ready++;
                chk(!p_rdy, "R8 ready single pulse", p_rdy, 0);
                chk(mem_addr == cur_addr, "R11 address at completion", mem_addr, cur_addr);
            end
        end
        p_oe = mem_oe_n; p_we = mem_we_n; p_ce = mem_ce_n; p_rdy = host_ready; p_addr = mem_addr;
    end

    // ---------------- driver ----------------
    task automatic run_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd, input logic [1:0] be);
        logic [DW-1:0] got, exp;
        @(negedge clk);
        cur_addr   = a;
        cur_wdata  = wd;
        cur_be     = be;
        host_req   = 1'b1;
        host_we    = we;
        host_addr  = a;
        host_wdata = wd;
        host_be    = be;
        n_ops++;
        do @(negedge clk); while (!host_ready);
        got = host_rdata;
        host_req = 1'b0;
        if (!we) begin
            exp = exp_read(a, be);
            if (be == 2'b00) chk(got == exp, "R10 read with no lanes", got, exp);
            else             chk(got == exp, "R2 read data", got, exp);
        end else begin
            logic [DW-1:0] w;
            w = shadow.exists(a) ? shadow[a] : init_word(a);
            w = (w & ~lane_mask(be)) | (wd & lane_mask(be));
            shadow[a] = w;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R8 watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        void'($urandom(32'd7391));
        repeat (4) @(negedge clk);
        // R1: reset state
        chk({mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, host_ready} == 6'b111110,
            "R1 reset strobes", {mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, host_ready}, 6'b111110);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, host_ready} == 6'b111110,
            "R1 idle after reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, host_ready}, 6'b111110);

        // Directed corner cases
        run_op(1'b1, 18'h00010, 16'hBEEF, 2'b11);   // full write
        run_op(1'b0, 18'h00010, 16'h0000, 2'b01);   // R2 lower lane only
        run_op(1'b0, 18'h00010, 16'h0000, 2'b10);   // R4 byte-only change
        run_op(1'b0, 18'h00010, 16'h0000, 2'b00);   // R10 no lanes
        run_op(1'b1, 18'h00010, 16'h1234, 2'b00);   // R10 write no lanes
        run_op(1'b0, 18'h00010, 16'h0000, 2'b11);   // expect BEEF
        run_op(1'b1, 18'h00010, 16'hA5C3, 2'b10);   // R3 upper only
        run_op(1'b0, 18'h00010, 16'h0000, 2'b11);   // expect A5EF
        run_op(1'b1, 18'h3FFFF, 16'h7E81, 2'b11);   // top address
        run_op(1'b0, 18'h3FFFF, 16'h0000, 2'b11);
        run_op(1'b0, 18'h00011, 16'h0000, 2'b11);   // read then write: R7
        run_op(1'b1, 18'h00011, 16'h0F0F, 2'b01);
        run_op(1'b0, 18'h00011, 16'h0000, 2'b11);

        // Constrained random mix
        for (int i = 0; i < 200; i++) begin
            logic [AW-1:0] a;
            a = (($urandom % 4) == 0) ? AW'(18'h3FFFF - ($urandom % 4)) : AW'($urandom % 12);
            run_op(1'(($urandom % 2)), a, 16'($urandom), 2'($urandom % 4));
        end

        repeat (8) @(negedge clk);
        chk(n_ready == n_ops, "R8 one ready per request", n_ready, n_ops);
        chk({mem_ce_n, mem_oe_n, mem_we_n} == 3'b111, "R8 idle at end", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
        finish_run();
    end

endmodule